// File: doc/BRIEF.md
# I2C Split-Bank GPIO Register Target

This block is an I2C target that lets a host controller reach two separate 32-bit words through one small window of four byte offsets. A read at an offset returns a byte of the input word. That word carries a firmware revision constant, a packed boot-status byte, the level of a user GPIO pin and spare status inputs. A write at the same offset changes the matching byte of an independent output word. The output word is registered and drives board-level controls, among them the user GPIO pin. The two banks never alias: writing offset 0x00 changes output byte 0 and leaves the revision that a read of 0x00 returns untouched.

A host first writes the offset byte and then sends data bytes. To read, it writes the offset, issues a repeated START and addresses the device for reading. The offset steps after every data byte and wraps within the four-byte window. SCL and SDA enter through a synchroniser and a glitch filter, and SDA is driven open-drain as a pull-low enable. The whole input word is captured when a read address matches, so every byte of a multi-byte read comes from one instant.

Top module: `i2c_gpio_bank_slave`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x20, for read and for write. Any other address is not acknowledged, and data bytes that follow it leave the output word unchanged.
- R2: In a write, the byte after the address is the offset and each later byte is a data byte. Offset k (0 to 3) writes bits [8k+7:8k] of the output word, and every data byte is acknowledged.
- R3: A write of the offset, then a repeated START and address+R, returns the input-word byte at that offset, MSB first.
- R4: Input byte 0 always reads as the FW_REV parameter. A write to offset 0x00 changes only output byte 0 and does not change what a read of offset 0x00 returns.
- R5: Input byte 1 reads, bit 7 down to bit 0, as: 0, 0, boot_img_type[1:0], pudc_level, boot_src_sw, boot_mode[1:0].
- R6: Output bit 16 is the user pin drive, and input bit 16 reads user_pin_in. Writing 0x01 to offset 0x02 sets output bit 16 to 1, and writing 0x00 there clears it. Input bits 31:17 read aux_in[14:0].
- R7: After each data byte, read or write, the offset advances by one and wraps from 0x03 to 0x00.
- R8: Offsets 0x04 to 0xFF are acknowledged. Writes to them leave the output word unchanged, and reads of them return 0x00.
- R9: The input word is captured when a read address is acknowledged. Changes to the inputs during a multi-byte read do not appear until the next read transaction.
- R10: After the host does not acknowledge a read byte, the target releases SDA, stays released and accepts a new transaction after STOP.
- R11: After reset the output word is all zeros and SDA is released.
- R12: A high pulse on SCL shorter than FILT_LEN clock samples is ignored and does not shift a bit.
- R13: The SDA pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level sensed from the bus |
| sda_i | input | 1 | SDA level sensed from the bus |
| sda_o | output | 1 | SDA output value, always low (open-drain) |
| sda_oe | output | 1 | SDA pull-low enable |
| boot_img_type | input | 2 | Boot image type, read in input byte 1 |
| pudc_level | input | 1 | Configuration pull-up pin level, read in input byte 1 |
| boot_src_sw | input | 1 | Boot selection source: 0 hardware, 1 software |
| boot_mode | input | 2 | Selected boot mode, read in input byte 1 |
| user_pin_in | input | 1 | Sensed level of the user GPIO pin (input bit 16) |
| aux_in | input | 15 | Spare status, input bits 31:17 |
| out_word | output | 32 | Registered output word; bit 16 drives the user pin |

## Verification
The bench tests the split between the banks by writing a byte to an offset and then reading the same offset. A design that shared one bank would return the written value and not the revision or the boot status. Offset wrap is exercised with writes and reads that start at offset 3: a design that did not wrap would put the fourth byte in an unused offset and return 0x00. An out-of-range write checks that the byte is acknowledged and dropped, so a design that truncated the offset would corrupt a real byte. Changing aux_in in the middle of a read shows whether the input word was captured once or sampled live, and a one-cycle SCL spike inside a data byte shows whether a weak filter shifts an extra bit and misaligns the byte.

// File: rtl/i2cg_pkg.sv
package i2cg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_OFFS,
      ST_OFFS_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK
   } tgt_state_e;

   // step the byte offset; wrap only out of the last mapped byte
   function automatic logic [7:0] next_offset(input logic [7:0] cur, input logic [7:0] last);
      return (cur == last) ? 8'h00 : cur + 8'h01;
   endfunction

endpackage

// File: rtl/i2cg_line_filter.sv
module i2cg_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES must be at least 2");
      assert (FILT_LEN >= 1)    else $fatal(1, "FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end

   generate
      if (FILT_LEN == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout_q <= 1'b1;
            else        dout_q <= sync_q[SYNC_STAGES-1];
         end
      end else begin : g_window
         logic [FILT_LEN-1:0] win_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q  <= '1;
               dout_q <= 1'b1;
            end else begin
               win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
               if (&win_q)       dout_q <= 1'b1;
               else if (~|win_q) dout_q <= 1'b0;
            end
         end
      end
   endgenerate

   assign dout = dout_q;

endmodule

// File: rtl/i2cg_target_fsm.sv
module i2cg_target_fsm
   import i2cg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h20,
   parameter int         NUM_REGS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_f,
   input  logic       sda_f,
   input  logic [7:0] rd_byte,
   output logic [7:0] rd_off,
   output logic       cap_stb,
   output logic       wr_stb,
   output logic [7:0] wr_off,
   output logic [7:0] wr_data,
   output logic       sda_oe,
   output logic       st_idle,
   output logic       off_adv,
   output logic [7:0] cur_off
);

   localparam logic [7:0] LAST_OFF = 8'(NUM_REGS - 1);
   localparam logic [3:0] BITS     = 4'd8;

   tgt_state_e state_q;
   logic       scl_d, sda_d;
   logic [3:0] bit_cnt_q;
   logic [7:0] shreg_q;
   logic [7:0] tx_q;
   logic [7:0] off_q;
   logic       rw_q;
   logic       nack_q;
   logic       oe_q;
   logic       cap_q, wr_q;
   logic [7:0] wr_off_q, wr_data_q;

   logic scl_rise, scl_fall, start_c, stop_c;

   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
   assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

   // during the host's ack slot the read path already looks at the next byte
   assign rd_off  = (state_q == ST_RDATA_ACK) ? next_offset(off_q, LAST_OFF) : off_q;
   assign off_adv = (state_q == ST_WDATA && scl_fall && bit_cnt_q == BITS) ||
                    (state_q == ST_RDATA_ACK && scl_fall && !nack_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         shreg_q   <= '0;
         tx_q      <= '0;
         off_q     <= '0;
         rw_q      <= 1'b0;
         nack_q    <= 1'b0;
         oe_q      <= 1'b0;
         cap_q     <= 1'b0;
         wr_q      <= 1'b0;
         wr_off_q  <= '0;
         wr_data_q <= '0;
      end else begin
         cap_q <= 1'b0;
         wr_q  <= 1'b0;
         if (start_c) begin
            state_q   <= ST_ADDR;
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
         end else if (stop_c) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise && bit_cnt_q < BITS) begin
                     shreg_q   <= {shreg_q[6:0], sda_f};
                     bit_cnt_q <= bit_cnt_q + 4'd1;
                  end else if (scl_fall && bit_cnt_q == BITS) begin
                     if (shreg_q[7:1] == DEV_ADDR) begin
                        oe_q    <= 1'b1;
                        rw_q    <= shreg_q[0];
                        cap_q   <= shreg_q[0];
                        state_q <= ST_ADDR_ACK;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        oe_q      <= ~rd_byte[7];
                        tx_q      <= {rd_byte[6:0], 1'b0};
                        bit_cnt_q <= 4'd1;
                        state_q   <= ST_RDATA;
                     end else begin
                        oe_q      <= 1'b0;
                        bit_cnt_q <= '0;
                        state_q   <= ST_OFFS;
                     end
                  end
               end
               ST_OFFS: begin
                  if (scl_rise && bit_cnt_q < BITS) begin
                     shreg_q   <= {shreg_q[6:0], sda_f};
                     bit_cnt_q <= bit_cnt_q + 4'd1;
                  end else if (scl_fall && bit_cnt_q == BITS) begin
                     off_q   <= shreg_q;
                     oe_q    <= 1'b1;
                     state_q <= ST_OFFS_ACK;
                  end
               end
               ST_OFFS_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     oe_q      <= 1'b0;
                     bit_cnt_q <= '0;
                     state_q   <= ST_WDATA;
                  end
               end
               ST_WDATA: begin
                  if (scl_rise && bit_cnt_q < BITS) begin
                     shreg_q   <= {shreg_q[6:0], sda_f};
                     bit_cnt_q <= bit_cnt_q + 4'd1;
                  end else if (scl_fall && bit_cnt_q == BITS) begin
                     wr_q      <= 1'b1;
                     wr_off_q  <= off_q;
                     wr_data_q <= shreg_q;
                     off_q     <= next_offset(off_q, LAST_OFF);
                     oe_q      <= 1'b1;
                     state_q   <= ST_WDATA_ACK;
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (bit_cnt_q == BITS) begin
                        oe_q      <= 1'b0;
                        bit_cnt_q <= '0;
                        state_q   <= ST_RDATA_ACK;
                     end else begin
                        oe_q      <= ~tx_q[7];
                        tx_q      <= {tx_q[6:0], 1'b0};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                     end
                  end
               end
               ST_RDATA_ACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_f;
                  end else if (scl_fall) begin
                     if (!nack_q) begin
                        off_q     <= next_offset(off_q, LAST_OFF);
                        oe_q      <= ~rd_byte[7];
                        tx_q      <= {rd_byte[6:0], 1'b0};
                        bit_cnt_q <= 4'd1;
                        state_q   <= ST_RDATA;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign cap_stb = cap_q;
   assign wr_stb  = wr_q;
   assign wr_off  = wr_off_q;
   assign wr_data = wr_data_q;
   assign sda_oe  = oe_q;
   assign st_idle = (state_q == ST_IDLE);
   assign cur_off = off_q;

endmodule

// File: rtl/i2cg_status_pack.sv
module i2cg_status_pack #(
   parameter int         NUM_REGS = 4,
   parameter logic [7:0] FW_REV   = 8'h05,
   localparam int        WORD_W   = NUM_REGS * 8,
   localparam int        AUX_W    = WORD_W - 17
) (
   input  logic [1:0]        boot_img_type,
   input  logic              pudc_level,
   input  logic              boot_src_sw,
   input  logic [1:0]        boot_mode,
   input  logic              user_pin_in,
   input  logic [AUX_W-1:0]  aux_in,
   output logic [WORD_W-1:0] in_word
);

   // bit 16 position is fixed by the output pin it mirrors
   assign in_word = {aux_in, user_pin_in, 2'b00, boot_img_type, pudc_level,
                     boot_src_sw, boot_mode, FW_REV};

endmodule

// File: rtl/i2cg_reg_banks.sv
module i2cg_reg_banks #(
   parameter int  NUM_REGS = 4,
   localparam int WORD_W   = NUM_REGS * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] in_word,
   input  logic              cap_stb,
   input  logic              wr_stb,
   input  logic [7:0]        wr_off,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        rd_off,
   output logic [7:0]        rd_byte,
   output logic [WORD_W-1:0] out_word
);

   logic [WORD_W-1:0] out_q;
   logic [WORD_W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q    <= '0;
         shadow_q <= '0;
      end else begin
         if (cap_stb) shadow_q <= in_word;
         if (wr_stb) begin
            for (int b = 0; b < NUM_REGS; b++) begin
               if (wr_off == 8'(b)) out_q[b*8 +: 8] <= wr_data;
            end
         end
      end
   end

   always_comb begin
      rd_byte = 8'h00;
      for (int b = 0; b < NUM_REGS; b++) begin
         if (rd_off == 8'(b)) rd_byte = shadow_q[b*8 +: 8];
      end
   end

   assign out_word = out_q;

endmodule

// File: rtl/i2c_gpio_bank_slave.sv
module i2c_gpio_bank_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h20,
   parameter logic [7:0] FW_REV      = 8'h05,
   parameter int         NUM_REGS    = 4,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   localparam int        WORD_W      = NUM_REGS * 8,
   localparam int        AUX_W       = WORD_W - 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              sda_oe,
   input  logic [1:0]        boot_img_type,
   input  logic              pudc_level,
   input  logic              boot_src_sw,
   input  logic [1:0]        boot_mode,
   input  logic              user_pin_in,
   input  logic [AUX_W-1:0]  aux_in,
   output logic [WORD_W-1:0] out_word
);

   initial begin : p_param_chk
      assert (NUM_REGS >= 3 && NUM_REGS <= 32)
         else $fatal(1, "NUM_REGS must hold the pin byte and stay small");
   end

   logic              scl_f, sda_f;
   logic [WORD_W-1:0] in_word;
   logic [7:0]        rd_byte, rd_off;
   logic              cap_stb, wr_stb;
   logic [7:0]        wr_off, wr_data;
   logic              st_idle, off_adv;
   logic [7:0]        cur_off;

   i2cg_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f)
   );

   i2cg_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f)
   );

   i2cg_status_pack #(.NUM_REGS(NUM_REGS), .FW_REV(FW_REV)) u_pack (
      .boot_img_type(boot_img_type), .pudc_level(pudc_level),
      .boot_src_sw(boot_src_sw), .boot_mode(boot_mode),
      .user_pin_in(user_pin_in), .aux_in(aux_in), .in_word(in_word)
   );

   i2cg_target_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .rd_byte(rd_byte), .rd_off(rd_off), .cap_stb(cap_stb),
      .wr_stb(wr_stb), .wr_off(wr_off), .wr_data(wr_data),
      .sda_oe(sda_oe), .st_idle(st_idle), .off_adv(off_adv), .cur_off(cur_off)
   );

   i2cg_reg_banks #(.NUM_REGS(NUM_REGS)) u_banks (
      .clk(clk), .rst_n(rst_n), .in_word(in_word), .cap_stb(cap_stb),
      .wr_stb(wr_stb), .wr_off(wr_off), .wr_data(wr_data),
      .rd_off(rd_off), .rd_byte(rd_byte), .out_word(out_word)
   );

   assign sda_o = 1'b0;

endmodule

// File: rtl/i2cg_bank_checker.sv
module i2cg_bank_checker #(
   parameter int  NUM_REGS = 4,
   localparam int WORD_W   = NUM_REGS * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic [WORD_W-1:0] out_word,
   input logic              wr_stb,
   input logic [7:0]        wr_off,
   input logic              st_idle,
   input logic              off_adv,
   input logic [7:0]        cur_off
);

   localparam logic [7:0] LAST_OFF = 8'(NUM_REGS - 1);

   a_r13_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);

   a_r2_out_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (out_word != $past(out_word)) |-> $past(wr_stb));

   a_r8_oob_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_off > LAST_OFF) |=> $stable(out_word));

   a_r7_offset_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (off_adv && cur_off == LAST_OFF) |=> (cur_off == 8'h00));

   a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      st_idle |-> !sda_oe);

endmodule

bind i2c_gpio_bank_slave i2cg_bank_checker #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .out_word(out_word), .wr_stb(wr_stb), .wr_off(wr_off),
   .st_idle(st_idle), .off_adv(off_adv), .cur_off(cur_off)
);

// File: tb/i2c_gpio_bank_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_gpio_bank_slave_tb_top;

   localparam logic [6:0] DEV    = 7'h20;
   localparam logic [7:0] TB_REV = 8'hA7;
   localparam int         Q      = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1;
   logic        sda_line;
   logic        sda_o, sda_oe;
   logic [1:0]  img = 2'b00, mode = 2'b00;
   logic        pudc = 1'b0, srcsw = 1'b0;
   logic [14:0] aux = 15'h0000;
   logic [31:0] out_word;
   logic [7:0]  wbuf [8];
   logic [7:0]  rbuf [8];
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_gpio_bank_slave #(.DEV_ADDR(DEV), .FW_REV(TB_REV)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe),
      .boot_img_type(img), .pudc_level(pudc), .boot_src_sw(srcsw),
      .boot_mode(mode), .user_pin_in(out_word[16]), .aux_in(aux),
      .out_word(out_word)
   );

   function automatic logic [31:0] exp_in();
      return {aux, out_word[16], 2'b00, img, pudc, srcsw, mode, TB_REV};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      sda_m = 1'b0; wt(2*Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      sda_m = 1'b1; wt(2*Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    wt(Q);
      scl_m = 1'b1; wt(2*Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      b = sda_line; wt(Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, input int glitch_at, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         send_bit(d[i]);
         if (i == glitch_at) begin
            wt(3);
            scl_m = 1'b1; wt(1);
            scl_m = 1'b0;
         end
      end
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~give_ack);
   endtask

   task automatic wr_seq(input logic [7:0] off, input int n, input int glitch_at);
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, -1, a); chk("R1 write address ack", a, 1);
      send_byte(off, -1, a);         chk("R8 offset ack", a, 1);
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], glitch_at, a);
         chk("R2 data ack", a, 1);
      end
      bus_stop();
   endtask

   task automatic rd_seq(input logic [7:0] off, input int n);
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, -1, a); chk("R1 write address ack", a, 1);
      send_byte(off, -1, a);         chk("R3 offset ack", a, 1);
      bus_start();
      send_byte({DEV, 1'b1}, -1, a); chk("R1 read address ack", a, 1);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
      chk("R10 sda released after host nack", {31'd0, sda_oe}, 0);
      bus_stop();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic        a;
      logic [31:0] expo, expi, oldi;
      wt(10);
      chk("R11 out_word after reset", out_word, 32'h0);
      chk("R11 sda released after reset", {31'd0, sda_oe}, 0);
      rst_n = 1'b1;
      wt(8);

      // R1: address sweep, only 0x20 acknowledged
      foreach (wbuf[i]) wbuf[i] = 8'hFF;
      for (int k = 0; k < 8; k++) begin
         logic [6:0] ad;
         ad = (k == 7) ? DEV : 7'((k * 19 + 1) ^ 7'h21);
         if (ad == DEV) ad = 7'h7F;
         bus_start();
         send_byte({ad, 1'b0}, -1, a);
         chk("R1 address ack decision", a, (ad == DEV));
         if (ad != DEV) begin
            send_byte(8'h00, -1, a);
            send_byte(8'hFF, -1, a);
         end
         bus_stop();
         chk("R1 foreign address leaves output", out_word, 32'h0);
      end

      // R2: single-byte write per offset
      expo = 32'h0;
      for (int o = 0; o < 4; o++) begin
         wbuf[0] = 8'(o * 8'h37 + 8'h12);
         wr_seq(8'(o), 1, -1);
         expo[o*8 +: 8] = wbuf[0];
         chk("R2 single byte write", out_word, expo);
      end
      // R2: burst from offset 0
      wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE; wbuf[3] = 8'hEF;
      wr_seq(8'h00, 4, -1);
      expo = 32'hEFBEADDE;
      chk("R2 burst write", out_word, expo);

      // R7: write wrap from offset 3
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      wr_seq(8'h03, 3, -1);
      expo = 32'hA1BEC3B2;
      chk("R7 write wraps 3 to 0", out_word, expo);

      // R3 R4 R5: read sweep over boot-status patterns
      for (int p = 0; p < 4; p++) begin
         img   = 2'(p);
         pudc  = p[0];
         srcsw = p[1];
         mode  = 2'(3 - p);
         aux   = 15'(p * 16'h1357 + 16'h0421);
         wt(4);
         expi = exp_in();
         rd_seq(8'h00, 4);
         chk("R4 byte 0 reads revision", rbuf[0], TB_REV);
         chk("R5 byte 1 boot packing", rbuf[1], {2'b00, img, pudc, srcsw, mode});
         chk("R3 byte 2 input", rbuf[2], expi[23:16]);
         chk("R3 byte 3 input", rbuf[3], expi[31:24]);
      end

      // R4: write offset 0, read back revision, output byte changed
      wbuf[0] = 8'h5A;
      wr_seq(8'h00, 1, -1);
      expo[7:0] = 8'h5A;
      chk("R4 output byte 0 written", out_word, expo);
      rd_seq(8'h00, 1);
      chk("R4 read of offset 0 still revision", rbuf[0], TB_REV);

      // R6: user pin drive and readback
      wbuf[0] = 8'h01;
      wr_seq(8'h02, 1, -1);
      chk("R6 pin drive high", {31'd0, out_word[16]}, 1);
      rd_seq(8'h02, 1);
      chk("R6 pin readback high", {24'd0, rbuf[0]}, {24'd0, aux[6:0], 1'b1});
      wbuf[0] = 8'h00;
      wr_seq(8'h02, 1, -1);
      chk("R6 pin drive low", {31'd0, out_word[16]}, 0);
      rd_seq(8'h02, 1);
      chk("R6 pin readback low", {24'd0, rbuf[0]}, {24'd0, aux[6:0], 1'b0});
      expo[23:16] = 8'h00;

      // R8: out-of-range offsets
      wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
      wr_seq(8'h05, 2, -1);
      chk("R8 out-of-range write ignored", out_word, expo);
      wbuf[0] = 8'h3C;
      wr_seq(8'hFF, 1, -1);
      chk("R8 offset 0xFF write ignored", out_word, expo);
      rd_seq(8'h09, 1);
      chk("R8 out-of-range read zero", rbuf[0], 8'h00);

      // R7: read wrap from offset 3
      expi = exp_in();
      rd_seq(8'h03, 5);
      chk("R7 read wrap byte3", rbuf[0], expi[31:24]);
      chk("R7 read wrap byte0", rbuf[1], expi[7:0]);
      chk("R7 read wrap byte1", rbuf[2], expi[15:8]);
      chk("R7 read wrap byte2", rbuf[3], expi[23:16]);
      chk("R7 read wrap byte3 again", rbuf[4], expi[31:24]);

      // R9: coherent snapshot during multi-byte read
      aux = 15'h1234;
      wt(4);
      oldi = exp_in();
      bus_start();
      send_byte({DEV, 1'b0}, -1, a);
      send_byte(8'h02, -1, a);
      bus_start();
      send_byte({DEV, 1'b1}, -1, a);
      recv_byte(1'b1, rbuf[0]);
      aux = 15'h6ACB;
      recv_byte(1'b1, rbuf[1]);
      recv_byte(1'b0, rbuf[2]);
      bus_stop();
      chk("R9 snapshot byte2", rbuf[0], oldi[23:16]);
      chk("R9 snapshot byte3 after input change", rbuf[1], oldi[31:24]);
      chk("R9 snapshot byte0", rbuf[2], oldi[7:0]);
      expi = exp_in();
      rd_seq(8'h03, 1);
      chk("R9 next read sees new input", rbuf[0], expi[31:24]);

      // R10: after host nack the target stays released and serves a write
      chk("R10 line high after stop", {31'd0, sda_line}, 1);
      wbuf[0] = 8'h77;
      wr_seq(8'h03, 1, -1);
      expo[31:24] = 8'h77;
      chk("R10 write after nacked read", out_word, expo);

      // R12: one-cycle SCL spike inside a data byte
      wbuf[0] = 8'h96;
      wr_seq(8'h01, 1, 4);
      expo[15:8] = 8'h96;
      chk("R12 spike on SCL ignored", out_word, expo);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule